// File: doc/BRIEF.md
# DMA Channel Register File with Chained Reload

This block keeps the programmable state of a four-channel DMA engine. For every channel it holds a 16-bit current address and a 16-bit count word. The count word carries a 14-bit transfer count and two transfer-type bits. One mode register holds the channel run enables and a chaining switch. One status register collects terminal-count events and a reload flag. The processor reaches all of these through an 8-bit register port. A shared byte toggle decides whether an access to an address or count register touches its low byte or its high byte.

An external bus-cycle engine arbitrates between the channels. When it finishes one transfer for a channel, it sends a single-cycle done strobe for that channel. On each strobe the block advances the channel's address and counts its count down. It flags the last transfer and pulses a mark output every 128 transfers. When chaining is on, channel 2 is reloaded from the parameters parked in channel 3 as soon as channel 2 finishes, so a second block can follow without processor help. The register port is a plain strobe interface with no back-pressure: every cycle with a read or write strobe is one complete access, and the port never stalls. Read data is valid during the read strobe cycle.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every address, count, mode and status bit is zero, the byte toggle points at the low byte, and `chan_en`, `tc_out` and `mark_out` are all low.
- R2: Each read or write to an address or count register uses the low byte when the toggle is clear and the high byte when it is set, then inverts the toggle. A write to the mode register returns the toggle to the low byte.
- R3: Register select 2n addresses channel n's address word and 2n+1 its count word (bits 13:0 count, bits 15:14 type). Select 8 writes the mode register (bits 3:0 channel enables, bit 4 chaining) and reads the status register (bits 3:0 terminal count per channel, bit 4 reload flag, bits 7:5 zero).
- R4: A done strobe on an enabled channel increments its address and decrements its count in the next cycle. A done strobe on a disabled channel changes nothing.
- R5: `tc_out[n]` is high while channel n is enabled and its count is zero. A done strobe in that state sets status bit n. Unless the channel is reloaded, the strobe also clears its enable bit, increments its address and leaves its count at zero.
- R6: Terminal-count status bits stay set until a status read. A status read returns the current value and clears bits 3:0 at the end of that strobe cycle. The read leaves bit 4 alone.
- R7: With chaining on, a write to a channel 2 register byte also writes the same byte of channel 3.
- R8: With chaining on, a terminal-count strobe on channel 2 copies channel 3's address and count word (type bits included) into channel 2, keeps channel 2 enabled, and sets status bit 4.
- R9: Status bit 4 clears on the next done strobe that channel 2 takes after the reload.
- R10: `mark_out[n]` pulses for one cycle, one cycle after the done strobe that completes transfer number 128, 256, and so on, counted from the last count write or reload of channel n.
- R11: A write to channel 3 made after the channel 2 write changes only channel 3, so the two channels can hold different values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per byte |
| bus_rd | input | 1 | Register read strobe, one cycle per byte |
| bus_sel | input | 4 | Register select |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, valid during the read strobe |
| xfer_done | input | 4 | Per-channel transfer-completed strobe |
| chan_en | output | 4 | Per-channel run enable |
| tc_out | output | 4 | Channel is on its last transfer |
| mark_out | output | 4 | Pulse after every 128th transfer |

## Verification
The assertions check on every cycle the things a single step shows. The address and count move by one per strobe. A terminal-count strobe sets its status bit and drops the enable. A reload copies channel 3 into channel 2 and keeps it running. Status bits hold until a read, the reload flag clears on the next channel 2 strobe, and the toggle flips on each access. The scenarios alone can show the byte order seen at the port, the mirrored writes under chaining and how later channel 3 writes split the two channels. They also show the exact value the status read returns, and that the mark comes at transfers 128 and 256 and at no other.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int unsigned DEF_NCH   = 4;
  localparam int unsigned DEF_AW    = 16;
  localparam int unsigned DEF_CW    = 14;
  localparam int unsigned DEF_TW    = 2;
  localparam int unsigned DEF_MK    = 7;
  localparam int unsigned DEF_SELW  = 4;
  localparam int unsigned DEF_DST   = 2;
  localparam int unsigned DEF_SRC   = 3;
endpackage

// File: rtl/dma_byte_flip.sv
module dma_byte_flip (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  input  logic to_low,
  output logic hi_sel
);
  always_ff @(posedge clk) begin
    if (!rst_n)      hi_sel <= 1'b0;
    else if (to_low) hi_sel <= 1'b0;
    else if (flip)   hi_sel <= ~hi_sel;
  end

  p_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && !to_low) |=> (hi_sel != $past(hi_sel)));
  p_mode_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    to_low |=> !hi_sel);
endmodule

// File: rtl/dma_chan_reg.sv
module dma_chan_reg #(
  parameter int unsigned AW = dma_regs_pkg::DEF_AW,
  parameter int unsigned CW = dma_regs_pkg::DEF_CW,
  parameter int unsigned TW = dma_regs_pkg::DEF_TW,
  parameter int unsigned MK = dma_regs_pkg::DEF_MK,
  localparam int unsigned RW = CW + TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_addr,
  input  logic          wr_cnt,
  input  logic          wr_hi,
  input  logic [7:0]    wdata,
  input  logic          step,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [RW-1:0] load_cnt,
  output logic [AW-1:0] addr_q,
  output logic [RW-1:0] cnt_q,
  output logic          at_zero,
  output logic          mark_q
);
  logic [MK-1:0] prog_q;
  logic [CW-1:0] count;

  assign count   = cnt_q[CW-1:0];
  assign at_zero = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      prog_q <= '0;
      mark_q <= 1'b0;
    end else begin
      mark_q <= 1'b0;
      if (load) begin
        addr_q <= load_addr;
        cnt_q  <= load_cnt;
        prog_q <= '0;
      end else begin
        if (wr_addr) begin
          if (wr_hi) addr_q[AW-1:8] <= wdata[AW-9:0];
          else       addr_q[7:0]    <= wdata;
        end else if (step) begin
          addr_q <= addr_q + 1'b1;
        end
        if (wr_cnt) begin
          if (wr_hi) cnt_q[RW-1:8] <= wdata[RW-9:0];
          else       cnt_q[7:0]    <= wdata;
          prog_q <= '0;
        end else if (step) begin
          if (!at_zero) cnt_q[CW-1:0] <= count - 1'b1;
          prog_q <= prog_q + 1'b1;
          mark_q <= &prog_q;
        end
      end
    end
  end

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_zero && !wr_cnt && !load) |=>
      (cnt_q[CW-1:0] == CW'($past(cnt_q[CW-1:0]) - 1'b1)));
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_addr && !load) |=> (addr_q == AW'($past(addr_q) + 1'b1)));
  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_zero && !wr_cnt && !load) |=> at_zero);
  p_load_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr_q == $past(load_addr) && cnt_q == $past(load_cnt)));
  p_mark_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mark_q |=> !mark_q);
endmodule

// File: rtl/dma_stat_reg.sv
module dma_stat_reg #(
  parameter int unsigned NCH = dma_regs_pkg::DEF_NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] tc_evt,
  input  logic           rd_clr,
  input  logic           upd_set,
  input  logic           upd_clr,
  output logic [NCH:0]   stat
);
  logic [NCH-1:0] tc_q;
  logic           upd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc_q  <= '0;
      upd_q <= 1'b0;
    end else begin
      tc_q <= (rd_clr ? '0 : tc_q) | tc_evt;
      if (upd_set)      upd_q <= 1'b1;
      else if (upd_clr) upd_q <= 1'b0;
    end
  end

  assign stat = {upd_q, tc_q};

  p_tc_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_evt) |=> ((stat[NCH-1:0] & $past(tc_evt)) == $past(tc_evt)));
  p_tc_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((stat[NCH-1:0] & $past(stat[NCH-1:0])) == $past(stat[NCH-1:0])));
  p_upd_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_set |=> stat[NCH]);
  p_upd_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_clr && !upd_set) |=> !stat[NCH]);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int unsigned NCH     = dma_regs_pkg::DEF_NCH,
  parameter int unsigned AW      = dma_regs_pkg::DEF_AW,
  parameter int unsigned CW      = dma_regs_pkg::DEF_CW,
  parameter int unsigned TW      = dma_regs_pkg::DEF_TW,
  parameter int unsigned MK      = dma_regs_pkg::DEF_MK,
  parameter int unsigned SELW    = dma_regs_pkg::DEF_SELW,
  parameter int unsigned RLD_DST = dma_regs_pkg::DEF_DST,
  parameter int unsigned RLD_SRC = dma_regs_pkg::DEF_SRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [SELW-1:0] bus_sel,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic [NCH-1:0]  xfer_done,
  output logic [NCH-1:0]  chan_en,
  output logic [NCH-1:0]  tc_out,
  output logic [NCH-1:0]  mark_out
);
  localparam int unsigned RW   = CW + TW;
  localparam int unsigned IDXW = SELW - 1;
  localparam logic [SELW-1:0] MODE_SEL = SELW'(2 * NCH);

  logic [NCH:0]    mode_q;
  logic            chain_on;
  logic [NCH-1:0]  en;
  logic            mode_sel, is_ch, is_cnt, mode_wr, hi_sel;
  logic [IDXW-1:0] ch_idx;
  logic [NCH-1:0]  at_zero, step, tc_evt, load_v, kill;
  logic [AW-1:0]   addr_arr [NCH];
  logic [RW-1:0]   cnt_arr  [NCH];
  logic [NCH:0]    stat;
  logic [AW-1:0]   rd_word;

  assign chain_on = mode_q[NCH];
  assign en       = mode_q[NCH-1:0];
  assign mode_sel = (bus_sel == MODE_SEL);
  assign is_ch    = (bus_sel < MODE_SEL);
  assign is_cnt   = bus_sel[0];
  assign ch_idx   = bus_sel[SELW-1:1];
  assign mode_wr  = bus_wr && mode_sel;

  dma_byte_flip u_flip (
    .clk    (clk),
    .rst_n  (rst_n),
    .flip   (is_ch && (bus_wr || bus_rd)),
    .to_low (mode_wr),
    .hi_sel (hi_sel)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam bit IS_SRC = (i == RLD_SRC);
    localparam bit IS_DST = (i == RLD_DST);
    logic hit;

    assign hit = bus_wr && is_ch &&
                 ((ch_idx == IDXW'(i)) ||
                  (IS_SRC && chain_on && ch_idx == IDXW'(RLD_DST)));
    assign step[i]   = xfer_done[i] && en[i];
    assign tc_evt[i] = step[i] && at_zero[i];
    assign load_v[i] = IS_DST && chain_on && tc_evt[i];
    assign kill[i]   = tc_evt[i] && !load_v[i];

    dma_chan_reg #(.AW(AW), .CW(CW), .TW(TW), .MK(MK)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_addr   (hit && !is_cnt),
      .wr_cnt    (hit && is_cnt),
      .wr_hi     (hi_sel),
      .wdata     (bus_wdata),
      .step      (step[i]),
      .load      (load_v[i]),
      .load_addr (addr_arr[RLD_SRC]),
      .load_cnt  (cnt_arr[RLD_SRC]),
      .addr_q    (addr_arr[i]),
      .cnt_q     (cnt_arr[i]),
      .at_zero   (at_zero[i]),
      .mark_q    (mark_out[i])
    );

    assign tc_out[i] = en[i] && at_zero[i];

    p_tc_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_evt[i] && !load_v[i] && !mode_wr) |=> !chan_en[i]);
    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[i] && !hit) |=> $stable(addr_arr[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_wr) mode_q <= bus_wdata[NCH:0];
    else              mode_q[NCH-1:0] <= en & ~kill;
  end

  dma_stat_reg #(.NCH(NCH)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .tc_evt  (tc_evt),
    .rd_clr  (bus_rd && mode_sel),
    .upd_set (load_v[RLD_DST]),
    .upd_clr (step[RLD_DST]),
    .stat    (stat)
  );

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NCH; k++) begin
      if (ch_idx == IDXW'(k)) rd_word = is_cnt ? AW'(cnt_arr[k]) : addr_arr[k];
    end
  end

  always_comb begin
    if (mode_sel)   bus_rdata = {{(7 - NCH){1'b0}}, stat};
    else if (is_ch) bus_rdata = hi_sel ? rd_word[AW-1:8] : rd_word[7:0];
    else            bus_rdata = '0;
  end

  assign chan_en = en;

  p_reload_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_v[RLD_DST] && !mode_wr) |=> chan_en[RLD_DST]);
  p_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_ch && !is_cnt && !hi_sel && chain_on &&
     ch_idx == IDXW'(RLD_DST) && !load_v[RLD_SRC]) |=>
      (addr_arr[RLD_SRC][7:0] == $past(bus_wdata)));
endmodule

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_sel = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] xfer_done = '0;
  logic [3:0] chan_en, tc_out, mark_out;

  int vectors = 0;
  int misses  = 0;

  always #4 clk = ~clk;

  dma_chan_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xfer_done(xfer_done), .chan_en(chan_en), .tc_out(tc_out),
    .mark_out(mark_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr8(input logic [3:0] sel, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] sel, input logic [15:0] d);
    wr8(sel, d[7:0]);
    wr8(sel, d[15:8]);
  endtask

  task automatic rd8(input logic [3:0] sel, output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_sel = sel;
    #2 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd16(input logic [3:0] sel, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd8(sel, lo);
    rd8(sel, hi);
    v = {hi, lo};
  endtask

  task automatic pulse(input logic [3:0] m, output logic [3:0] mk);
    @(negedge clk);
    xfer_done = m;
    @(negedge clk);
    mk = mark_out;
    xfer_done = '0;
  endtask

  initial begin
    #(8 * 200000);
    misses++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [15:0] w, keep;
    logic [7:0]  b;
    logic [3:0]  mk;
    int          marks;
    int          first_mark;
    int          second_mark;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 chan_en", chan_en, 0);
    chk("R1 tc_out", tc_out, 0);
    chk("R1 mark_out", mark_out, 0);
    rd8(4'd8, b);  chk("R1 status", b, 0);
    rd16(4'd2, w); chk("R1 ch1 addr", w, 0);

    // R2 toggle, reset by mode write
    wr8(4'd0, 8'h11);
    wr8(4'd8, 8'h00);
    wr8(4'd0, 8'h22);
    wr8(4'd0, 8'h33);
    rd8(4'd0, b); chk("R2 low byte first", b, 8'h22);
    rd8(4'd0, b); chk("R2 high byte second", b, 8'h33);

    // R3 R4 R5 sweep across channels, no chaining
    for (int ch = 0; ch < 4; ch++) begin
      automatic logic [15:0] base = 16'h0100 * ch + 16'h0040;
      automatic int n = ch + 2;
      automatic int oth = (ch + 1) % 4;
      wr16(4'(2 * ch), base);
      wr16(4'(2 * ch + 1), 16'h4000 | 16'(n));
      wr8(4'd8, 8'(1 << ch));
      // R4 strobe on a disabled channel is ignored
      rd16(4'(2 * oth), keep);
      pulse(4'(1 << oth), mk);
      rd16(4'(2 * oth), w); chk("R4 disabled ignored", w, keep);
      for (int k = 0; k <= n; k++) begin
        chk("R5 tc_out level", 32'(tc_out[ch]), 32'(k == n));
        pulse(4'(1 << ch), mk);
        rd16(4'(2 * ch), w);
        chk("R4 addr step", w, base + 16'(k + 1));
        rd16(4'(2 * ch + 1), w);
        chk("R3 R4 count step", w, 16'h4000 | ((k < n) ? 16'(n - k - 1) : 16'h0));
      end
      chk("R5 enable cleared", 32'(chan_en[ch]), 0);
      rd8(4'd8, b); chk("R5 R6 status set", b, 8'(1 << ch));
      rd8(4'd8, b); chk("R6 status cleared by read", b, 0);
    end

    // R6 stays set across unrelated accesses
    wr16(4'd0, 16'h0500);
    wr16(4'd1, 16'h0000);
    wr8(4'd8, 8'h01);
    pulse(4'b0001, mk);
    rd16(4'd0, w); chk("R6 addr after tc", w, 16'h0501);
    rd8(4'd8, b);  chk("R6 sticky", b, 8'h01);
    rd8(4'd8, b);  chk("R6 cleared", b, 8'h00);

    // R7 R11 R8 R9 chaining
    wr8(4'd8, 8'h14);
    wr16(4'd4, 16'h1000);
    wr16(4'd5, 16'h0002);
    rd16(4'd6, w); chk("R7 mirror addr", w, 16'h1000);
    rd16(4'd7, w); chk("R7 mirror count", w, 16'h0002);
    wr16(4'd6, 16'h2000);
    wr16(4'd7, 16'h8001);
    rd16(4'd4, w); chk("R11 ch2 addr kept", w, 16'h1000);
    rd16(4'd5, w); chk("R11 ch2 count kept", w, 16'h0002);
    rd16(4'd6, w); chk("R11 ch3 addr", w, 16'h2000);
    pulse(4'b0100, mk);
    pulse(4'b0100, mk);
    chk("R5 tc_out ch2", 32'(tc_out[2]), 1);
    pulse(4'b0100, mk);
    chk("R8 ch2 still enabled", 32'(chan_en[2]), 1);
    rd16(4'd4, w); chk("R8 reload addr", w, 16'h2000);
    rd16(4'd5, w); chk("R8 reload count", w, 16'h8001);
    rd8(4'd8, b);  chk("R8 status tc and update", b, 8'h14);
    rd8(4'd8, b);  chk("R6 read keeps update flag", b, 8'h10);
    pulse(4'b0100, mk);
    rd8(4'd8, b);  chk("R9 update flag cleared", b, 8'h00);
    rd16(4'd5, w); chk("R9 count after next step", w, 16'h8000);
    rd16(4'd4, w); chk("R9 addr after next step", w, 16'h2001);

    // R10 mark every 128 transfers
    wr8(4'd8, 8'h02);
    wr16(4'd2, 16'h0000);
    wr16(4'd3, 16'd299);
    marks = 0; first_mark = -1; second_mark = -1;
    for (int k = 0; k < 300; k++) begin
      pulse(4'b0010, mk);
      if (mk[1]) begin
        marks++;
        if (first_mark < 0) first_mark = k;
        else if (second_mark < 0) second_mark = k;
      end
    end
    chk("R10 mark count", 32'(marks), 2);
    chk("R10 first mark at 128th", 32'(first_mark), 127);
    chk("R10 second mark at 256th", 32'(second_mark), 255);
    chk("R5 ch1 stopped", 32'(chan_en[1]), 0);
    rd8(4'd8, b); chk("R5 ch1 status", b, 8'h02);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule